// File: doc/BRIEF.md
# Dual-Mode Interrupt Controller Register Front End

This block is the register access front end of a local interrupt controller. One register file of 32-bit words is reachable through two address spaces. The legacy port takes memory-mapped reads and writes at byte offsets, and each offset must sit on a 16-byte boundary. The extended port takes indexed accesses. Its index is the legacy offset shifted right by four, plus a base of 0x800. Both ports land on the same storage. Interrupt delivery and the timer are not part of this block. It only holds the words those functions use.

The block keeps two control bits: a global enable and an extended-mode select. It accepts only legal changes to them. Entering extended mode is a single step. Leaving it has to pass through the fully disabled state. Illegal requests are dropped and latch a sticky fault flag. Some words behave differently in each mode. The identifier reads as an 8-bit field in the top byte in legacy mode, and as a read-only 32-bit hardware value in extended mode. The command word is two 32-bit halves in legacy mode and one 64-bit word in extended mode. The destination-format word cannot be reached from the extended port.

Every accepted request gets exactly one response, two clock cycles after it is presented. The response carries a valid bit, an error bit and 64 data bits. Writes and rejected accesses return zero data.

Top module: `irq_dual_regs`

## Requirements
- R1: After synchronous reset the enable bit reads 1, the extended bit reads 0, the fault flag reads 0 and no response is valid.
- R2: In legacy mode an aligned access at offset `o` reads or writes word `o>>4`. The response appears two cycles after the request, with bits 63:32 zero. A write responds with zero data and no error.
- R3: A legacy access whose offset has a nonzero low nibble, or whose word number is 64 or more (offset 0x400 and up), is rejected. It responds with error=1 and zero data, and it changes no word.
- R4: Writing enable=1, extended=1 from legacy mode enters extended mode directly. From extended mode, writing enable=0, extended=0 disables the block. A following write of enable=1, extended=0 returns it to legacy mode.
- R5: A mode write that would clear only the extended bit while enable stays 1, or that requests enable=0 with extended=1, is ignored. It sets the fault flag, which stays set until reset.
- R6: In extended mode, index 0x800 + n reaches the same word n as legacy offset n*16. Indices below 0x800 or at 0x840 and above are rejected with error=1.
- R7: In extended mode, the destination-format word (word 14, index 0x80E) and the upper command half (word 49, index 0x831) are rejected with error=1.
- R8: In extended mode, index 0x830 reads and writes the 64-bit command word. In legacy mode, offset 0x300 holds its bits 31:0 and offset 0x310 holds its bits 63:32.
- R9: The identifier is word 2 (offset 0x20). In legacy mode it reads back as {stored 8 bits, 24 zeros}, and a write stores data bits 31:24. Reset loads the stored byte from `hw_id[7:0]`. In extended mode it reads as the full `hw_id`, and a write is accepted without error but changes nothing.
- R10: A legacy-port access while in extended mode responds with error=1 and zero data, and sets the fault flag.
- R11: While the enable bit is 0 every access on either port is rejected, and so is an extended-port access in legacy mode. Neither case sets the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_id | input | 32 | Hardware-assigned identifier |
| mode_wr | input | 1 | Request a change of the two control bits |
| mode_en_in | input | 1 | Requested enable bit |
| mode_ext_in | input | 1 | Requested extended-mode bit |
| mm_req | input | 1 | Legacy-port request, one cycle per access |
| mm_we | input | 1 | Legacy-port write when 1, read when 0 |
| mm_off | input | 12 | Legacy byte offset |
| mm_wdata | input | 32 | Legacy write data |
| x_req | input | 1 | Extended-port request, one cycle per access |
| x_we | input | 1 | Extended-port write when 1, read when 0 |
| x_idx | input | 12 | Extended register index |
| x_wdata | input | 64 | Extended write data |
| rsp_valid | output | 1 | Response valid, two cycles after a request |
| rsp_err | output | 1 | Request was rejected |
| rsp_data | output | 64 | Read data, zero for writes and rejects |
| mode_en | output | 1 | Current enable bit |
| mode_ext | output | 1 | Current extended-mode bit |
| fault_flag | output | 1 | Sticky fault flag |

## Verification
The assertions assume a single requester: `mm_req` and `x_req` are never high in the same cycle, and each request is a one-cycle pulse. The legacy port takes priority if both are raised. The stimulus always drives one port at a time and returns the request lines to zero before the next access. It waits for each response before starting another, so every request has its own response window. Mode writes are never issued together with an access, and the read-only `hw_id` input is held constant throughout.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;

  // Classification of one request after address and mode decode.
  typedef enum logic [3:0] {
    K_NONE,
    K_REJECT,
    K_FAULT,
    K_MEM,
    K_ID_LEG,
    K_ID_EXT,
    K_ICR_LO,
    K_ICR_HI,
    K_ICR_FULL
  } acc_kind_e;

  // Word numbers whose behaviour depends on the access mode.
  localparam int unsigned SLOT_ID     = 2;
  localparam int unsigned SLOT_DFMT   = 14;
  localparam int unsigned SLOT_ICR_LO = 48;
  localparam int unsigned SLOT_ICR_HI = 49;

endpackage

// File: rtl/irq_rf_mode.sv
module irq_rf_mode (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic want_en,
  input  logic want_ext,
  input  logic acc_fault,
  output logic en_q,
  output logic ext_q,
  output logic fault_q
);

  logic bad_combo;
  logic bad_exit;
  logic legal;

  always_comb begin
    // Extended mode without the enable bit is not a valid state.
    bad_combo = want_ext && !want_en;
    // Leaving extended mode must go through the disabled state.
    bad_exit  = ext_q && want_en && !want_ext;
    legal     = !bad_combo && !bad_exit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b1;
      ext_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (wr && legal) begin
        en_q  <= want_en;
        ext_q <= want_ext;
      end
      if ((wr && !legal) || acc_fault) begin
        fault_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_rf_decode.sv
module irq_rf_decode
  import irq_rf_pkg::*;
#(
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned SLOT_W = 6,
  parameter int unsigned XBASE  = 32'h800
) (
  input  logic              en,
  input  logic              ext,
  input  logic              mm_req,
  input  logic              mm_we,
  input  logic [OFF_W-1:0]  mm_off,
  input  logic              x_req,
  input  logic              x_we,
  input  logic [IDX_W-1:0]  x_idx,
  output acc_kind_e         kind,
  output logic [SLOT_W-1:0] slot,
  output logic              is_wr,
  output logic              acc_fault
);

  logic [IDX_W-1:0] rel;

  always_comb begin
    kind  = K_NONE;
    slot  = '0;
    is_wr = 1'b0;
    rel   = x_idx - IDX_W'(XBASE);
    if (mm_req) begin
      is_wr = mm_we;
      slot  = mm_off[SLOT_W+3:4];
      if (!en) begin
        kind = K_REJECT;
      end else if (ext) begin
        kind = K_FAULT;
      end else if ((mm_off[3:0] != 4'd0) || ((mm_off >> (SLOT_W + 4)) != '0)) begin
        kind = K_REJECT;
      end else if (slot == SLOT_W'(SLOT_ID)) begin
        kind = K_ID_LEG;
      end else if (slot == SLOT_W'(SLOT_ICR_LO)) begin
        kind = K_ICR_LO;
      end else if (slot == SLOT_W'(SLOT_ICR_HI)) begin
        kind = K_ICR_HI;
      end else begin
        kind = K_MEM;
      end
    end else if (x_req) begin
      is_wr = x_we;
      slot  = rel[SLOT_W-1:0];
      if (!en || !ext) begin
        kind = K_REJECT;
      end else if ((rel >> SLOT_W) != '0) begin
        kind = K_REJECT;
      end else if (slot == SLOT_W'(SLOT_ID)) begin
        kind = K_ID_EXT;
      end else if (slot == SLOT_W'(SLOT_DFMT) || slot == SLOT_W'(SLOT_ICR_HI)) begin
        kind = K_REJECT;
      end else if (slot == SLOT_W'(SLOT_ICR_LO)) begin
        kind = K_ICR_FULL;
      end else begin
        kind = K_MEM;
      end
    end
    acc_fault = (kind == K_FAULT);
  end

endmodule

// File: rtl/irq_rf_array.sv
module irq_rf_array #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Single write port, registered read: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/irq_dual_regs.sv
module irq_dual_regs
  import irq_rf_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned LID_W = 8,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 12,
  parameter int unsigned XBASE = 32'h800
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   hw_id,
  input  logic            mode_wr,
  input  logic            mode_en_in,
  input  logic            mode_ext_in,
  input  logic            mm_req,
  input  logic            mm_we,
  input  logic [OFF_W-1:0] mm_off,
  input  logic [DW-1:0]   mm_wdata,
  input  logic            x_req,
  input  logic            x_we,
  input  logic [IDX_W-1:0] x_idx,
  input  logic [2*DW-1:0] x_wdata,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [2*DW-1:0] rsp_data,
  output logic            mode_en,
  output logic            mode_ext,
  output logic            fault_flag
);

  localparam int unsigned SLOT_W = $clog2(DEPTH);
  localparam int unsigned XW     = 2 * DW;

  acc_kind_e         kind;
  logic [SLOT_W-1:0] slot;
  logic              is_wr;
  logic              acc_fault;
  logic [XW-1:0]     wd;
  logic              mem_we;
  logic [DW-1:0]     mem_q;

  logic [LID_W-1:0]  id_q;
  logic [XW-1:0]     icr_q;
  logic [XW-1:0]     spec_rd;

  logic              s1_v;
  logic              s1_wr;
  acc_kind_e         s1_kind;
  logic [XW-1:0]     s1_spec;
  logic              s1_err;

  irq_rf_decode #(
    .OFF_W (OFF_W),
    .IDX_W (IDX_W),
    .SLOT_W(SLOT_W),
    .XBASE (XBASE)
  ) u_dec (
    .en       (mode_en),
    .ext      (mode_ext),
    .mm_req   (mm_req),
    .mm_we    (mm_we),
    .mm_off   (mm_off),
    .x_req    (x_req),
    .x_we     (x_we),
    .x_idx    (x_idx),
    .kind     (kind),
    .slot     (slot),
    .is_wr    (is_wr),
    .acc_fault(acc_fault)
  );

  irq_rf_mode u_mode (
    .clk      (clk),
    .rst      (rst),
    .wr       (mode_wr),
    .want_en  (mode_en_in),
    .want_ext (mode_ext_in),
    .acc_fault(acc_fault),
    .en_q     (mode_en),
    .ext_q    (mode_ext),
    .fault_q  (fault_flag)
  );

  always_comb begin
    wd     = mm_req ? {{DW{1'b0}}, mm_wdata} : x_wdata;
    mem_we = is_wr && (kind == K_MEM);
  end

  irq_rf_array #(
    .DW   (DW),
    .DEPTH(DEPTH),
    .AW   (SLOT_W)
  ) u_arr (
    .clk  (clk),
    .we   (mem_we),
    .waddr(slot),
    .wdata(wd[DW-1:0]),
    .raddr(slot),
    .rdata(mem_q)
  );

  // Identifier byte and the 64-bit command word live in flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      id_q  <= hw_id[LID_W-1:0];
      icr_q <= '0;
    end else if (is_wr) begin
      case (kind)
        K_ID_LEG:   id_q            <= wd[DW-1 -: LID_W];
        K_ICR_LO:   icr_q[DW-1:0]   <= wd[DW-1:0];
        K_ICR_HI:   icr_q[XW-1:DW]  <= wd[DW-1:0];
        K_ICR_FULL: icr_q           <= wd;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_ID_LEG:   spec_rd = {{DW{1'b0}}, id_q, {(DW-LID_W){1'b0}}};
      K_ID_EXT:   spec_rd = {{DW{1'b0}}, hw_id};
      K_ICR_LO:   spec_rd = {{DW{1'b0}}, icr_q[DW-1:0]};
      K_ICR_HI:   spec_rd = {{DW{1'b0}}, icr_q[XW-1:DW]};
      K_ICR_FULL: spec_rd = icr_q;
      default:    spec_rd = '0;
    endcase
  end

  // Stage 1: decode result and special-word data, alongside the RAM read.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_wr   <= 1'b0;
      s1_kind <= K_NONE;
      s1_spec <= '0;
    end else begin
      s1_v    <= (kind != K_NONE);
      s1_wr   <= is_wr;
      s1_kind <= kind;
      s1_spec <= spec_rd;
    end
  end

  always_comb begin
    s1_err = (s1_kind == K_REJECT) || (s1_kind == K_FAULT);
  end

  // Stage 2: registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= s1_v;
      rsp_err   <= s1_v && s1_err;
      if (!s1_v || s1_wr || s1_err) begin
        rsp_data <= '0;
      end else if (s1_kind == K_MEM) begin
        rsp_data <= {{DW{1'b0}}, mem_q};
      end else begin
        rsp_data <= s1_spec;
      end
    end
  end

endmodule

// File: rtl/irq_dual_regs_chk.sv
module irq_dual_regs_chk #(
  parameter int unsigned XW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          mm_req,
  input logic          x_req,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [XW-1:0] rsp_data,
  input logic          mode_en,
  input logic          mode_ext,
  input logic          fault_flag
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mode_en && !mode_ext && !fault_flag && !rsp_valid));

  a_r2_rsp_latency: assert property (@(posedge clk) disable iff (rst)
    (mm_req || x_req) |-> ##2 rsp_valid);

  a_r3_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

  a_r4_exit_via_disable: assert property (@(posedge clk) disable iff (rst)
    (!mode_ext && $past(mode_ext)) |-> !mode_en);

  a_r5_ext_needs_en: assert property (@(posedge clk) disable iff (rst)
    mode_ext |-> mode_en);

  a_r5_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    fault_flag |=> fault_flag);

  a_r10_legacy_in_ext_faults: assert property (@(posedge clk) disable iff (rst)
    (mm_req && mode_en && mode_ext) |=> fault_flag);

endmodule

bind irq_dual_regs irq_dual_regs_chk #(.XW(2*DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mm_req    (mm_req),
  .x_req     (x_req),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_data  (rsp_data),
  .mode_en   (mode_en),
  .mode_ext  (mode_ext),
  .fault_flag(fault_flag)
);

// File: tb/tb_irq_dual_regs.sv
module tb_irq_dual_regs;

  localparam logic [31:0] HWID = 32'h1234_5678;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr = 1'b0, mode_en_in = 1'b0, mode_ext_in = 1'b0;
  logic        mm_req = 1'b0, mm_we = 1'b0;
  logic [11:0] mm_off = '0;
  logic [31:0] mm_wdata = '0;
  logic        x_req = 1'b0, x_we = 1'b0;
  logic [11:0] x_idx = '0;
  logic [63:0] x_wdata = '0;
  logic        rsp_valid, rsp_err, mode_en, mode_ext, fault_flag;
  logic [63:0] rsp_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_dual_regs dut (
    .clk(clk), .rst(rst), .hw_id(HWID),
    .mode_wr(mode_wr), .mode_en_in(mode_en_in), .mode_ext_in(mode_ext_in),
    .mm_req(mm_req), .mm_we(mm_we), .mm_off(mm_off), .mm_wdata(mm_wdata),
    .x_req(x_req), .x_we(x_we), .x_idx(x_idx), .x_wdata(x_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .mode_en(mode_en), .mode_ext(mode_ext), .fault_flag(fault_flag)
  );

  function automatic logic [31:0] pat(input int s);
    return (32'h9E37_79B9 * (s + 1)) ^ {4{8'(s)}};
  endfunction

  task automatic chk(input string tag, input logic [65:0] act, input logic [65:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // One access; compares {valid, err, data} two cycles later.
  task automatic acc(input string tag, input bit use_x, input bit we,
                     input logic [11:0] addr, input logic [63:0] wdat,
                     input bit exp_err, input logic [63:0] exp_data);
    @(negedge clk);
    if (use_x) begin
      x_req = 1'b1; x_we = we; x_idx = addr; x_wdata = wdat;
    end else begin
      mm_req = 1'b1; mm_we = we; mm_off = addr; mm_wdata = wdat[31:0];
    end
    @(posedge clk);
    @(negedge clk);
    x_req = 1'b0; mm_req = 1'b0; x_we = 1'b0; mm_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(tag, {rsp_valid, rsp_err, rsp_data}, {1'b1, exp_err, exp_data});
  endtask

  task automatic set_mode(input bit en, input bit ext);
    @(negedge clk);
    mode_wr = 1'b1; mode_en_in = en; mode_ext_in = ext;
    @(posedge clk);
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  function automatic logic [63:0] leg_exp(input int s);
    if (s == 2) return {32'd0, pat(2)[31:24], 24'd0};
    return {32'd0, pat(s)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset state", {62'd0, mode_en, mode_ext, fault_flag, rsp_valid}, {62'd0, 4'b1000});
    // R9 identifier after reset
    acc("R9 reset id", 1'b0, 1'b0, 12'h020, '0, 1'b0, {32'd0, HWID[7:0], 24'd0});

    // R2 legacy write sweep then read sweep
    for (int s = 0; s < 64; s++)
      acc("R2 legacy write", 1'b0, 1'b1, 12'(s * 16), {32'd0, pat(s)}, 1'b0, '0);
    for (int s = 0; s < 64; s++)
      acc("R2 legacy read", 1'b0, 1'b0, 12'(s * 16), '0, 1'b0, leg_exp(s));

    // R3 misaligned and out-of-range offsets
    for (int k = 1; k < 16; k++)
      acc("R3 misaligned", 1'b0, 1'b1, 12'(12'h040 + k), 64'hDEAD, 1'b1, '0);
    acc("R3 out of range", 1'b0, 1'b1, 12'h400, 64'hBEEF, 1'b1, '0);
    acc("R3 word unchanged", 1'b0, 1'b0, 12'h040, '0, 1'b0, {32'd0, pat(4)});
    acc("R3 word0 unchanged", 1'b0, 1'b0, 12'h000, '0, 1'b0, {32'd0, pat(0)});

    // R11 extended port in legacy mode
    acc("R11 ext in legacy", 1'b1, 1'b0, 12'h804, '0, 1'b1, '0);
    chk("R11 no fault", {65'd0, fault_flag}, 66'd0);

    // R4 enter extended mode
    set_mode(1'b1, 1'b1);
    chk("R4 enter ext", {64'd0, mode_en, mode_ext}, {64'd0, 2'b11});

    // R6/R7/R8/R9 extended sweep
    for (int s = 0; s < 64; s++) begin
      if (s == 14 || s == 49)
        acc("R7 ext reject", 1'b1, 1'b0, 12'(12'h800 + s), '0, 1'b1, '0);
      else if (s == 2)
        acc("R9 ext id", 1'b1, 1'b0, 12'h802, '0, 1'b0, {32'd0, HWID});
      else if (s == 48)
        acc("R8 ext icr", 1'b1, 1'b0, 12'h830, '0, 1'b0, {pat(49), pat(48)});
      else
        acc("R6 ext read", 1'b1, 1'b0, 12'(12'h800 + s), '0, 1'b0, {32'd0, pat(s)});
    end
    acc("R6 below base", 1'b1, 1'b0, 12'h7FF, '0, 1'b1, '0);
    acc("R6 above range", 1'b1, 1'b0, 12'h840, '0, 1'b1, '0);
    acc("R6 ext write", 1'b1, 1'b1, 12'h805, 64'hFFFF_0000_CAFE_F00D, 1'b0, '0);
    acc("R6 ext write read", 1'b1, 1'b0, 12'h805, '0, 1'b0, 64'h0000_0000_CAFE_F00D);

    // R8 64-bit command word
    acc("R8 icr write", 1'b1, 1'b1, 12'h830, 64'h0123_4567_89AB_CDEF, 1'b0, '0);
    acc("R8 icr read", 1'b1, 1'b0, 12'h830, '0, 1'b0, 64'h0123_4567_89AB_CDEF);
    // R9 id write ignored in extended mode
    acc("R9 ext id write", 1'b1, 1'b1, 12'h802, 64'h0000_0000_FFFF_FFFF, 1'b0, '0);
    acc("R9 ext id kept", 1'b1, 1'b0, 12'h802, '0, 1'b0, {32'd0, HWID});
    chk("R11 fault clear", {65'd0, fault_flag}, 66'd0);

    // R10 legacy port in extended mode
    acc("R10 legacy in ext", 1'b0, 1'b0, 12'h040, '0, 1'b1, '0);
    chk("R10 fault set", {65'd0, fault_flag}, {65'd0, 1'b1});

    // R5 illegal direct exit
    set_mode(1'b1, 1'b0);
    chk("R5 direct exit ignored", {64'd0, mode_en, mode_ext}, {64'd0, 2'b11});
    chk("R5 fault sticky", {65'd0, fault_flag}, {65'd0, 1'b1});

    // R4 two-step exit
    set_mode(1'b0, 1'b0);
    chk("R4 disabled", {64'd0, mode_en, mode_ext}, {64'd0, 2'b00});
    acc("R11 legacy disabled", 1'b0, 1'b0, 12'h040, '0, 1'b1, '0);
    acc("R11 ext disabled", 1'b1, 1'b0, 12'h804, '0, 1'b1, '0);
    set_mode(1'b1, 1'b0);
    chk("R4 back to legacy", {64'd0, mode_en, mode_ext}, {64'd0, 2'b10});
    acc("R8 legacy icr low", 1'b0, 1'b0, 12'h300, '0, 1'b0, 64'h0000_0000_89AB_CDEF);
    acc("R8 legacy icr high", 1'b0, 1'b0, 12'h310, '0, 1'b0, 64'h0000_0000_0123_4567);
    acc("R9 legacy id kept", 1'b0, 1'b0, 12'h020, '0, 1'b0, leg_exp(2));
    acc("R6 legacy sees ext write", 1'b0, 1'b0, 12'h050, '0, 1'b0, 64'h0000_0000_CAFE_F00D);

    // R5 invalid combination from a clean state
    do_reset();
    chk("R1 fault cleared", {65'd0, fault_flag}, 66'd0);
    set_mode(1'b0, 1'b1);
    chk("R5 invalid combo ignored", {64'd0, mode_en, mode_ext}, {64'd0, 2'b10});
    chk("R5 invalid combo fault", {65'd0, fault_flag}, {65'd0, 1'b1});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule